// File: doc/BRIEF.md
# Byte Load/Store Adapter for a Word-Only Memory

The adapter gives a requester byte-granular loads and stores on top of a 32-bit memory. That memory can only read or write whole words and has no per-byte write strobes. The requester presents a byte address, a size (byte or word), a write flag and write data, together with a valid strobe. It then waits for a one-cycle done pulse, which carries the read data and an error flag.

Word accesses at aligned addresses pass straight through to the memory. A byte load fetches the word that contains the byte and returns the addressed lane, zero-extended. A byte store is a read-modify-write sequence. It fetches the containing word, masks out the target lane, ORs in the shifted new byte, and writes the whole word back. The neighbouring bytes therefore keep their values.

The backing word memory is modelled inside the block. It is cleared by reset.

Top module: `byte_word_adapter`

## Requirements
- R1: The memory is word addressed. The word index is the byte address with bits [1:0] dropped, so byte addresses 4k..4k+3 all fall in word k, and an aligned word written at one index is read back unchanged without disturbing any other index.
- R2: A byte load returns in rdata_o[7:0] the lane chosen by address bits [1:0]. Lane 0 is bits [7:0] and lane 3 is bits [31:24] (little-endian). rdata_o[31:8] is zero.
- R3: A byte store replaces only the addressed lane of the containing word. The other three bytes of that word keep their previous values.
- R4: An aligned word load returns the full stored word. An aligned word store writes all 32 bits of req_wdata_i.
- R5: A word access whose address bits [1:0] are nonzero raises err_o together with done_o. It leaves memory unchanged and returns rdata_o = 0. Byte accesses never raise err_o.
- R6: done_o is a single-cycle pulse. Counted in clock edges after the edge that accepts the request, it rises after 1 edge for a misaligned word access, after 2 edges for a byte load, word load or word store, and after 4 edges for a byte store.
- R7: While a request is in progress (from acceptance until done_o has pulsed), req_valid_i is ignored. A request presented during that time has no effect on memory.
- R8: After reset, done_o, err_o and rdata_o are low, and every memory word reads as zero.
- R9: rdata_o is zero except in the done cycle of a load that did not fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken only when idle |
| req_addr_i | input | ADDR_W | Byte address |
| req_word_i | input | 1 | 1 = word access, 0 = byte access |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_wdata_i | input | 32 | Store data (byte stores use bits [7:0]) |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Misaligned word access, valid with done_o |
| rdata_o | output | 32 | Load result, valid with done_o |

## Verification
If the lane select is wrong, the error shows at the first byte load or store that reaches a nonzero lane: either the wrong byte is returned, or a neighbouring byte is corrupted and the next word read of that index shows it. If the sequencer skips or repeats a state, the done pulse arrives at the wrong cycle. A skipped modify step instead writes stale merge data, which the following word read of that index exposes. If a request slips in while the block is busy, it overwrites the word before the pending store completes, and a read-back straight after the sequence shows the mismatch.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  localparam int DATA_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int LANES   = DATA_W / BYTE_W;
  localparam int LANE_W  = $clog2(LANES);

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_MODIFY = 3'd2,
    ST_WRITE  = 3'd3,
    ST_DONE   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/bwa_word_mem.sv
module bwa_word_mem
  import bwa_pkg::*;
#(
  parameter int WA_W = 6,
  localparam int WORDS = 1 << WA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic              we_i,
  input  logic [WA_W-1:0]   addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [WORDS];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      if (re_i) rdata_q <= mem_q[addr_i];
    end
  end

  assign rdata_o = rdata_q;

  // one port: read and write never share a cycle
  assert_rw_exclusive_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(re_i && we_i));
endmodule

// File: rtl/bwa_lane_unit.sv
module bwa_lane_unit
  import bwa_pkg::*;
(
  input  logic [DATA_W-1:0] word_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic [DATA_W-1:0] merged_o
);
  logic [4:0]        shamt;
  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] shifted_down;
  logic [DATA_W-1:0] shifted_up;

  assign shamt        = {lane_i, 3'b000};
  assign lane_mask    = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}} << shamt;
  assign shifted_down = word_i >> shamt;
  assign shifted_up   = {{(DATA_W-BYTE_W){1'b0}}, byte_i} << shamt;
  assign byte_o       = shifted_down[BYTE_W-1:0];
  assign merged_o     = (word_i & ~lane_mask) | shifted_up;
endmodule

// File: rtl/bwa_seq.sv
module bwa_seq
  import bwa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic word_i,
  input  logic we_i,
  input  logic misalign_i,
  output logic accept_o,
  output logic mem_re_o,
  output logic mod_en_o,
  output logic mem_we_o,
  output logic done_o,
  output logic err_o,
  output logic busy_o
);
  seq_state_e state_q, state_d;
  logic rmw_q, err_q;

  assign accept_o = (state_q == ST_IDLE) && valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (valid_i) begin
        if (word_i && misalign_i) state_d = ST_DONE;
        else if (word_i && we_i)  state_d = ST_WRITE;
        else                      state_d = ST_READ;
      end
      ST_READ:   state_d = rmw_q ? ST_MODIFY : ST_DONE;
      ST_MODIFY: state_d = ST_WRITE;
      ST_WRITE:  state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rmw_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) begin
        rmw_q <= !word_i && we_i;
        err_q <= word_i && misalign_i;
      end
    end
  end

  assign mem_re_o = (state_q == ST_READ);
  assign mod_en_o = (state_q == ST_MODIFY);
  assign mem_we_o = (state_q == ST_WRITE);
  assign done_o   = (state_q == ST_DONE);
  assign err_o    = done_o && err_q;
  assign busy_o   = (state_q != ST_IDLE);

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_write_then_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> done_o);
  assert_modify_then_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_en_o |=> mem_we_o);
endmodule

// File: rtl/byte_word_adapter.sv
module byte_word_adapter
  import bwa_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_word_i,
  input  logic              req_we_i,
  input  logic [31:0]       req_wdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [31:0]       rdata_o
);
  localparam int WA_W = ADDR_W - LANE_W;

  logic              accept, mem_re, mod_en, mem_we, busy, seq_done, seq_err;
  logic [ADDR_W-1:0] addr_q;
  logic              word_q, we_q;
  logic [DATA_W-1:0] wdata_q, merge_q;
  logic [DATA_W-1:0] mem_rdata, mem_wdata, merged;
  logic [BYTE_W-1:0] lane_byte;
  logic [WA_W-1:0]   word_addr;
  logic [LANE_W-1:0] lane_sel;

  bwa_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (req_valid_i),
    .word_i     (req_word_i),
    .we_i       (req_we_i),
    .misalign_i (req_addr_i[LANE_W-1:0] != '0),
    .accept_o   (accept),
    .mem_re_o   (mem_re),
    .mod_en_o   (mod_en),
    .mem_we_o   (mem_we),
    .done_o     (seq_done),
    .err_o      (seq_err),
    .busy_o     (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      word_q  <= 1'b0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      merge_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr_i;
        word_q  <= req_word_i;
        we_q    <= req_we_i;
        wdata_q <= req_wdata_i;
      end
      if (mod_en) merge_q <= merged;
    end
  end

  assign word_addr = addr_q[ADDR_W-1:LANE_W];
  assign lane_sel  = addr_q[LANE_W-1:0];
  assign mem_wdata = word_q ? wdata_q : merge_q;

  bwa_lane_unit u_lane (
    .word_i   (mem_rdata),
    .lane_i   (lane_sel),
    .byte_i   (wdata_q[BYTE_W-1:0]),
    .byte_o   (lane_byte),
    .merged_o (merged)
  );

  bwa_word_mem #(.WA_W(WA_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .re_i    (mem_re),
    .we_i    (mem_we),
    .addr_i  (word_addr),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rdata)
  );

  always_comb begin
    rdata_o = '0;
    if (seq_done && !seq_err && !we_q)
      rdata_o = word_q ? mem_rdata : {{(DATA_W-BYTE_W){1'b0}}, lane_byte};
  end

  assign done_o = seq_done;
  assign err_o  = seq_err;

  // untouched lanes go back exactly as fetched
  for (genvar l = 0; l < LANES; l++) begin : g_keep
    assert_keep_lane_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_we && !word_q && lane_sel != l)
        |-> mem_wdata[l*BYTE_W +: BYTE_W] == mem_rdata[l*BYTE_W +: BYTE_W]);
  end

  assert_err_no_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !$past(mem_we));
  assert_hold_while_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(addr_q) && $stable(wdata_q)));
  assert_err_only_word_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> word_q);
endmodule

// File: tb/sim_byte_word_adapter.sv
`timescale 1ns/1ps
module sim_byte_word_adapter;
  localparam int ADDR_W = 8;
  localparam int WORDS  = 1 << (ADDR_W - 2);

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_word = 1'b0;
  logic              req_we = 1'b0;
  logic [31:0]       req_wdata = '0;
  logic              done_o, err_o;
  logic [31:0]       rdata_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;
  logic [31:0] model [WORDS];

  always #4 clk = ~clk;

  byte_word_adapter #(.ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_word_i(req_word), .req_we_i(req_we), .req_wdata_i(req_wdata),
    .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic wait_done(output logic [31:0] rd, output logic er, output int lat);
    lat = 1;
    while (!done_o && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    rd = rdata_o;
    er = err_o;
    @(negedge clk);
    check("R6 done single pulse", {31'b0, done_o}, 32'd0);
  endtask

  task automatic do_req(input logic [ADDR_W-1:0] a, input logic w, input logic we,
                        input logic [31:0] d, output logic [31:0] rd,
                        output logic er, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_word = w; req_we = we; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(rd, er, lat);
  endtask

  function automatic logic [31:0] pat(input int i);
    return (i * 32'h9E37_79B1) ^ 32'hA5A5_0F0F;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] rd, exp;
    logic er;
    int lat;

    for (int i = 0; i < WORDS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R8 reset state
    check("R8 done after reset", {31'b0, done_o}, 0);
    check("R8 err after reset", {31'b0, err_o}, 0);
    check("R8 rdata after reset", rdata_o, 0);
    do_req(8'h00, 1, 0, 0, rd, er, lat);
    check("R8 word 0 cleared", rd, 0);
    do_req(8'hFC, 1, 0, 0, rd, er, lat);
    check("R8 last word cleared", rd, 0);

    // R4/R1 aligned word stores everywhere
    for (int i = 0; i < WORDS; i++) begin
      do_req(ADDR_W'(i * 4), 1, 1, pat(i), rd, er, lat);
      model[i] = pat(i);
      check("R6 word store latency", lat, 2);
      check("R9 rdata zero on store", rd, 0);
    end
    for (int i = 0; i < WORDS; i++) begin
      do_req(ADDR_W'(i * 4), 1, 0, 0, rd, er, lat);
      check("R4 R1 word read back", rd, model[i]);
      check("R6 word load latency", lat, 2);
    end

    // R2 byte loads over every address
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      do_req(ADDR_W'(a), 0, 0, 0, rd, er, lat);
      exp = (model[a / 4] >> (8 * (a % 4))) & 32'hFF;
      check("R2 byte load", rd, exp);
      check("R6 byte load latency", lat, 2);
      check("R5 byte no err", {31'b0, er}, 0);
    end

    // R3 byte stores over every address
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      logic [7:0] b;
      b = 8'(a * 7 + 3);
      do_req(ADDR_W'(a), 0, 1, {24'hDEAD_BE, b}, rd, er, lat);
      model[a / 4] = (model[a / 4] & ~(32'hFF << (8 * (a % 4))))
                   | ({24'b0, b} << (8 * (a % 4)));
      check("R6 byte store latency", lat, 4);
      if (a % 4 == 1) begin
        do_req(ADDR_W'((a / 4) * 4), 1, 0, 0, rd, er, lat);
        check("R3 neighbours kept", rd, model[a / 4]);
      end
    end
    for (int i = 0; i < WORDS; i++) begin
      do_req(ADDR_W'(i * 4), 1, 0, 0, rd, er, lat);
      check("R3 R1 word after byte stores", rd, model[i]);
    end

    // R5 misaligned word accesses
    for (int off = 1; off < 4; off++) begin
      do_req(ADDR_W'(32 + off), 1, 1, 32'hFFFF_FFFF, rd, er, lat);
      check("R5 misaligned store err", {31'b0, er}, 1);
      check("R6 err latency", lat, 1);
      do_req(ADDR_W'(32 + off), 1, 0, 0, rd, er, lat);
      check("R5 misaligned load err", {31'b0, er}, 1);
      check("R5 misaligned load rdata", rd, 0);
    end
    do_req(8'h20, 1, 0, 0, rd, er, lat);
    check("R5 memory unchanged", rd, model[8]);

    // R7 request during a byte store is ignored
    @(negedge clk);
    req_valid = 1; req_addr = 8'h11; req_word = 0; req_we = 1; req_wdata = 32'h5A;
    @(negedge clk);
    req_addr = 8'h10; req_word = 1; req_we = 1; req_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    req_valid = 0;
    begin
      int l2;
      wait_done(rd, er, l2);
      check("R7 R6 store latency with busy request", l2 + 1, 4);
    end
    model[4] = (model[4] & 32'hFFFF_00FF) | 32'h0000_5A00;
    do_req(8'h10, 1, 0, 0, rd, er, lat);
    check("R7 busy request ignored", rd, model[4]);

    finish_run();
  end
endmodule